// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Serial Result Output

This block is the digital half of a successive-approximation analog-to-digital converter. An external conversion-start line is watched on every falling clock edge. When a low-to-high change is seen, the block places the track/hold in hold and starts a binary search. On each edge it presents a trial code to an external DAC and reads back a single comparator bit. The search settles one bit per clock, most significant bit first.

While the search runs, the block sends a serial frame on one data pin. The frame is a leading high marker bit followed by the result, most significant bit first, in two's complement. The DAC search code is offset binary, so the serial result is the final code with its top bit inverted. Every register, including the serial pin, changes only on the falling clock edge, so a receiver can capture bits on the rising edge. After the last result bit the track/hold goes back to track. Clock edges that arrive between conversions leave the block untouched.

The idle level of the data pin is set by a parameter. With the parameter clear, the pin is driven low and its enable stays high. With it set, the enable is dropped outside the frame so the pin can be floated.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is high, and on the first edge after it, track_hold is 0, serial_out is 0 and dac_code is all zeros. serial_oe is 1 when IDLE_HIZ is 0 and 0 when IDLE_HIZ is 1.
- R2: A conversion starts on the falling edge where conv_start is sampled 1 after having been sampled 0 on the previous falling edge. On that edge track_hold goes to 1 and dac_code becomes a value with only its top bit set. If conv_start is already high when reset is released, no conversion starts until it has been sampled low.
- R3: On each of the next NBITS edges the comparator bit comp_in is sampled, where 1 means the input is at or above dac_code. The bit under trial is kept on 1 and cleared on 0, and the next lower bit is set as the new trial. After the NBITS-th such edge, dac_code equals the largest code not above the input.
- R4: On the first edge after the start edge, serial_out goes to 1 (the marker bit). On each of the following NBITS edges it carries one result bit, most significant first.
- R5: The serial result is two's complement: each result bit equals the matching bit of the final dac_code, except that the top bit is inverted.
- R6: track_hold stays 1 for exactly NBITS+1 edges after the start edge and returns to 0 on the (NBITS+1)-th one.
- R7: conv_start is ignored while a conversion runs. A new rising change during it has no effect, and a level that is still high when the conversion ends does not start another one.
- R8: Between frames, extra clock edges change nothing: serial_out stays 0, track_hold stays 0 and dac_code keeps the last result.
- R9: With IDLE_HIZ set to 1, serial_oe is 1 only on the edges that carry a frame bit (marker or result) and 0 otherwise. With IDLE_HIZ set to 0, it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start request; rising change starts a conversion |
| comp_in | input | 1 | Comparator result: 1 when the held input is at or above dac_code |
| dac_code | output | NBITS | Trial code to the DAC, offset binary |
| track_hold | output | 1 | 1 = hold, 0 = track |
| serial_out | output | 1 | Serial frame: marker bit, then two's-complement result MSB first |
| serial_oe | output | 1 | Drive enable for serial_out |

## Verification
The bench builds two copies with NBITS set to 6, one with IDLE_HIZ cleared and one with it set. The narrow width makes the full sweep of all 64 input codes short. That sweep covers every keep/clear path of the search and both results of the inverted top bit. The two copies together exercise both idle drive choices. Some conversions raise a second start edge part-way through and leave the start line high past the end. Those runs give the ignore rule and the no-effect check on idle edges a definite window to look at.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } phase_e;

  // Actions decoded for the coming falling edge
  typedef struct packed {
    logic launch;   // start edge seen: hold, load MSB trial
    logic decide;   // resolve one trial bit from comparator
    logic marker;   // drive leading high flag
    logic shift;    // drive one result bit
    logic last;     // final edge of the conversion
  } step_t;

endpackage

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
#(
  parameter int NBITS = 12,
  localparam int CW = $clog2(NBITS + 2),
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_start,
  output step_t         step,
  output logic [IW-1:0] trial_idx,
  output logic [IW-1:0] out_idx,
  output logic          busy
);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          start_prev_q;
  logic [CW-1:0] trial_full;
  logic [CW-1:0] out_full;

  assign busy = (phase_q == PH_CONV);

  always_comb begin
    step        = '0;
    step.launch = !busy && conv_start && !start_prev_q;
    step.decide = busy && (cnt_q < CW'(NBITS));
    step.marker = busy && (cnt_q == '0);
    step.shift  = busy && (cnt_q != '0) && (cnt_q <= CW'(NBITS));
    step.last   = busy && (cnt_q == CW'(NBITS));
  end

  // bit under trial: NBITS-1-cnt ; bit being sent: NBITS-cnt
  assign trial_full = CW'(NBITS - 1) - cnt_q;
  assign out_full   = CW'(NBITS) - cnt_q;
  assign trial_idx  = trial_full[IW-1:0];
  assign out_idx    = out_full[IW-1:0];

  always_ff @(negedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      start_prev_q <= 1'b1;
    end else begin
      start_prev_q <= conv_start;
      if (step.launch) begin
        phase_q <= PH_CONV;
        cnt_q   <= '0;
      end else if (step.last) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar
  import sarseq_pkg::*;
#(
  parameter int NBITS = 12,
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  step_t            step,
  input  logic [IW-1:0]    trial_idx,
  input  logic             comp_in,
  output logic [NBITS-1:0] code
);

  logic [NBITS-1:0] code_q;
  logic [NBITS-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (step.launch) begin
      code_d = '0;
      code_d[NBITS-1] = 1'b1;
    end else if (step.decide) begin
      for (int i = 0; i < NBITS; i++) begin
        if (IW'(i) == trial_idx) code_d[i] = comp_in;
        if (i + 1 < NBITS && IW'(i + 1) == trial_idx) code_d[i] = 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/sarseq_tx.sv
module sarseq_tx
  import sarseq_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter bit IDLE_HIZ = 1'b0,
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  step_t            step,
  input  logic             busy,
  input  logic [IW-1:0]    out_idx,
  input  logic [NBITS-1:0] code,
  output logic             serial_out,
  output logic             serial_oe
);

  logic [NBITS-1:0] twos;
  logic             out_q;
  logic             oe_q;

  // offset binary to two's complement
  assign twos = {~code[NBITS-1], code[NBITS-2:0]};

  always_ff @(negedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (step.marker) begin
      out_q <= 1'b1;
    end else if (step.shift) begin
      out_q <= twos[out_idx];
    end else begin
      out_q <= 1'b0;
    end
  end

  generate
    if (IDLE_HIZ) begin : g_float
      always_ff @(negedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= busy;
      end
    end else begin : g_drive
      always_ff @(negedge clk) begin
        if (rst) oe_q <= 1'b1;
        else     oe_q <= 1'b1;
      end
    end
  endgenerate

  assign serial_out = out_q;
  assign serial_oe  = oe_q;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sarseq_pkg::*;
#(
  parameter int NBITS    = 12,
  parameter bit IDLE_HIZ = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             comp_in,
  output logic [NBITS-1:0] dac_code,
  output logic             track_hold,
  output logic             serial_out,
  output logic             serial_oe
);

  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

  step_t         step;
  logic [IW-1:0] trial_idx;
  logic [IW-1:0] out_idx;
  logic          busy;

  sarseq_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .step       (step),
    .trial_idx  (trial_idx),
    .out_idx    (out_idx),
    .busy       (busy)
  );

  sarseq_sar #(.NBITS(NBITS)) u_sar (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .trial_idx (trial_idx),
    .comp_in   (comp_in),
    .code      (dac_code)
  );

  sarseq_tx #(.NBITS(NBITS), .IDLE_HIZ(IDLE_HIZ)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .busy       (busy),
    .out_idx    (out_idx),
    .code       (dac_code),
    .serial_out (serial_out),
    .serial_oe  (serial_oe)
  );

  // busy is a register, so hold is registered too
  assign track_hold = busy;

endmodule

// File: rtl/sarseq_checker.sv
module sarseq_checker #(
  parameter int NBITS = 12,
  localparam int HW = $clog2(NBITS + 3)
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_start,
  input logic             comp_in,
  input logic [NBITS-1:0] dac_code,
  input logic             track_hold,
  input logic             serial_out,
  input logic             serial_oe
);

  logic [HW-1:0] hold_len;

  always_ff @(negedge clk) begin
    if (rst || !track_hold) hold_len <= '0;
    else                    hold_len <= hold_len + 1'b1;
  end

  // R2: hold only begins after the start line was seen high
  assert_start_edge_R2: assert property (@(negedge clk) disable iff (rst)
    $rose(track_hold) |-> $past(conv_start));

  // R4: marker bit follows the start edge
  assert_marker_first_R4: assert property (@(negedge clk) disable iff (rst)
    $rose(track_hold) |=> serial_out);

  // R6: hold lasts exactly NBITS+1 edges
  assert_hold_length_R6: assert property (@(negedge clk) disable iff (rst)
    $fell(track_hold) |-> (hold_len == HW'(NBITS + 1)));

  assert_hold_bound_R6: assert property (@(negedge clk) disable iff (rst)
    hold_len <= HW'(NBITS + 1));

  // R8: idle output is low and the code is frozen
  assert_idle_low_R8: assert property (@(negedge clk) disable iff (rst)
    (!track_hold && !$past(track_hold)) |-> !serial_out);

  assert_idle_code_R8: assert property (@(negedge clk) disable iff (rst)
    !track_hold |-> $stable(dac_code));

  // R9: output is enabled whenever a frame bit is on the pin
  assert_frame_enabled_R9: assert property (@(negedge clk) disable iff (rst)
    $past(track_hold) |-> serial_oe);

endmodule

bind sar_serial_seq sarseq_checker #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;

  localparam int N = 6;
  localparam int NCODES = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_start = 1'b0;
  logic [N-1:0] samp = '0;
  logic [N-1:0] dac_a, dac_b;
  logic         hold_a, hold_b, out_a, out_b, oe_a, oe_b;
  logic         comp_a, comp_b;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign comp_a = (samp >= dac_a);
  assign comp_b = (samp >= dac_b);

  sar_serial_seq #(.NBITS(N), .IDLE_HIZ(1'b0)) u_dut (
    .clk(clk), .rst(rst), .conv_start(conv_start), .comp_in(comp_a),
    .dac_code(dac_a), .track_hold(hold_a), .serial_out(out_a), .serial_oe(oe_a));

  sar_serial_seq #(.NBITS(N), .IDLE_HIZ(1'b1)) u_dut_z (
    .clk(clk), .rst(rst), .conv_start(conv_start), .comp_in(comp_b),
    .dac_code(dac_b), .track_hold(hold_b), .serial_out(out_b), .serial_oe(oe_b));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_edge();
    @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle_checks(input int code, input string tag);
    chk({tag, " R8 out low"}, out_a, 0);
    chk({tag, " R8 hold low"}, hold_a, 0);
    chk({tag, " R8 code kept"}, dac_a, code);
    chk({tag, " R9 oe drive"}, oe_a, 1);
    chk({tag, " R9 oe float"}, oe_b, 0);
  endtask

  task automatic convert(input int code, input bit retrig);
    int exp_bit;
    int part;
    conv_start = 1'b0;
    samp = N'(code);
    step_edge();
    conv_start = 1'b1;
    step_edge();                     // start edge F0
    chk("R2 hold set", hold_a, 1);
    chk("R3 msb trial", dac_a, 1 << (N - 1));
    chk("R2 hold set hz", hold_b, 1);
    for (int k = 1; k <= N + 1; k++) begin
      step_edge();
      if (k == 1) exp_bit = 1;
      else exp_bit = ((code ^ (1 << (N - 1))) >> (N + 1 - k)) & 1;
      chk(k == 1 ? "R4 marker" : "R5 result bit", out_a, exp_bit);
      chk("R4 hz copy", out_b, exp_bit);
      chk("R9 oe frame", oe_b, 1);
      chk("R6 hold", hold_a, (k <= N) ? 1 : 0);
      if (k < N) begin
        part = ((code >> (N - k)) << (N - k)) | (1 << (N - 1 - k));
        chk("R3 trial", dac_a, part);
      end else begin
        chk("R3 final", dac_a, code);
      end
      if (retrig && k == 2) conv_start = 1'b0;
      if (retrig && k == 4) conv_start = 1'b1;
    end
    step_edge();
    idle_checks(code, "post");
    if (retrig) begin
      for (int j = 0; j < 4; j++) begin
        step_edge();
        idle_checks(code, "R7 no retrigger");
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    conv_start = 1'b1;               // high through reset release
    repeat (3) step_edge();
    chk("R1 hold", hold_a, 0);
    chk("R1 out", out_a, 0);
    chk("R1 code", dac_a, 0);
    chk("R1 oe drive", oe_a, 1);
    chk("R1 oe float", oe_b, 0);
    rst = 1'b0;
    step_edge();
    chk("R1 first edge hold", hold_a, 0);
    chk("R1 first edge oe", oe_b, 0);
    repeat (3) begin
      step_edge();
      chk("R2 no start while held high", hold_a, 0);
      chk("R2 code untouched", dac_a, 0);
    end
    // exhaustive sweep over all input codes
    for (int c = 0; c < NCODES; c++) convert(c, (c % 4) == 3);
    // idle clocking with start low
    conv_start = 1'b0;
    repeat (6) begin
      step_edge();
      idle_checks(NCODES - 1, "R8 idle clocks");
    end
    convert(0, 1'b0);
    convert(NCODES - 1, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule